// File: doc/BRIEF.md
# Indirect Command Register Bridge

This block gives a host access to a large, function-indexed internal register window through four directly mapped host registers. The host first loads a 32-bit data word, then writes a control word that carries a function identifier, a window address and a direction flag. That control write is itself the trigger: the bridge checks the target address against its access class. It then either issues one request on a generic internal request/response port or finishes the command locally.

A write command sends the staged data word, the function identifier and the window address to the internal port. A read command fetches a 64-bit value and splits it across a low and a high data register for the host to read back. Window addresses fall into write-only, read-only and reserved classes. Reserved reads return zero. A command in the wrong direction for its class is blocked and raises a sticky error flag. A busy bit covers the time an internal access is outstanding.

Top module: `ircb_bridge`

## Requirements
- R1: After reset the low data register, the high data register, the busy bit and the error flag all read as zero, and no request is presented.
- R2: Host offsets are 0 = low data (read/write), 1 = high data (read only; writes have no effect), 2 = control (write triggers a command; reads return zero), 3 = status (bit 0 busy, bit 1 error). In the control word, bits [15:0] are the function identifier, bits [27:16] are the window address, bits [30:28] are ignored, and bit 31 selects write (1) or read (0).
- R3: A write command to a write-only address presents one request with write flag 1. The request carries the function identifier, the window address and the low data value held at trigger time. Write-only addresses are 0x400–0x487, 0x500–0x587 and 0x5A0–0x5A2.
- R4: A read command to a read-only address presents one request with write flag 0. The 64-bit response is stored with bits [31:0] in the low data register and bits [63:32] in the high data register. Read-only addresses are 0x200 and 0x5A3–0x5A6.
- R5: A read command to a reserved address (any address in neither class) loads zero into both data registers, issues no request and leaves the error flag unchanged.
- R6: A write command to a read-only or reserved address issues no request and sets the error flag.
- R7: A read command to a write-only address loads zero into both data registers, issues no request and sets the error flag.
- R8: Busy is set by an accepted command and stays set until the internal response arrives. A control write seen while busy, including in the cycle the response arrives, is ignored and sets the error flag.
- R9: The error flag stays set until the host writes status with bit 1 high.
- R10: While a request waits for ready, the request valid, address, function identifier, write flag and data stay unchanged, even if the host rewrites the low data register.
- R11: A read response that arrives in the same cycle as a host write to the low data register takes priority, so the low register holds the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| req_valid | output | 1 | Internal request valid |
| req_ready | input | 1 | Internal request accepted |
| req_write | output | 1 | Request direction, 1 = write |
| req_addr | output | 12 | Request window address |
| req_fid | output | 16 | Request function identifier |
| req_wdata | output | 32 | Request write data |
| rsp_valid | input | 1 | Internal response valid |
| rsp_data | input | 64 | Internal response data |

## Verification
The internal response can land in the same clock edge as a host register write, and two such collisions matter here. In the first, a read response meets a host write to the low data register, and the response must win. In the second, the response meets a new control write, and that write must still be refused as busy and flagged. The bench times a one-cycle target reply so that the response edge matches the edge on which the following host write is sampled. It then judges the outcome from the low data register, the status error bit and the count of request handshakes seen on the internal port.

// File: rtl/ircb_pkg.sv
// Package: shared types and host register offsets for the indirect command bridge.
// Assumes a 2-bit host offset space.
package ircb_pkg;

    typedef enum logic [1:0] {
        CLS_RSV = 2'd0,
        CLS_WO  = 2'd1,
        CLS_RO  = 2'd2
    } win_class_e;

    localparam logic [1:0] OFF_DLO  = 2'd0;
    localparam logic [1:0] OFF_DHI  = 2'd1;
    localparam logic [1:0] OFF_CTRL = 2'd2;
    localparam logic [1:0] OFF_STAT = 2'd3;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_ERR_BIT  = 1;

endpackage

// File: rtl/ircb_win_decode.sv
// Module: sorts a window address into write-only, read-only or reserved.
// Assumes the ranges do not overlap. Read-only hits are checked first.
module ircb_win_decode
    import ircb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NWO    = 3,
    parameter int NRO    = 2,
    parameter int WO_LO [NWO] = '{32'h400, 32'h500, 32'h5A0},
    parameter int WO_HI [NWO] = '{32'h487, 32'h587, 32'h5A2},
    parameter int RO_LO [NRO] = '{32'h200, 32'h5A3},
    parameter int RO_HI [NRO] = '{32'h200, 32'h5A6}
) (
    input  logic [ADDR_W-1:0] addr,
    output win_class_e        cls
);

    logic [NWO-1:0] wo_hit;
    logic [NRO-1:0] ro_hit;

    // One range comparator per write-only window.
    for (genvar g = 0; g < NWO; g++) begin : g_wo
        assign wo_hit[g] = (addr >= ADDR_W'(WO_LO[g])) && (addr <= ADDR_W'(WO_HI[g]));
    end

    // One range comparator per read-only window.
    for (genvar g = 0; g < NRO; g++) begin : g_ro
        assign ro_hit[g] = (addr >= ADDR_W'(RO_LO[g])) && (addr <= ADDR_W'(RO_HI[g]));
    end

    // Merge the range hits into a single class.
    always_comb begin
        if (|ro_hit)      cls = CLS_RO;
        else if (|wo_hit) cls = CLS_WO;
        else              cls = CLS_RSV;
    end

endmodule

// File: rtl/ircb_sequencer.sv
// Module: runs one internal access. It holds the request until ready, then waits for the response.
// Assumes the target answers every accepted request, reads and writes alike, with one rsp_valid pulse.
module ircb_sequencer #(
    parameter int FID_W  = 16,
    parameter int ADDR_W = 12,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              launch_write,
    input  logic [ADDR_W-1:0] launch_addr,
    input  logic [FID_W-1:0]  launch_fid,
    input  logic [DW-1:0]     launch_wdata,
    output logic              busy,
    output logic              rd_done,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [FID_W-1:0]  req_fid,
    output logic [DW-1:0]     req_wdata,
    input  logic              rsp_valid
);

    typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} seq_state_e;
    seq_state_e state_q;

    // Step through idle, request and wait-for-response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            case (state_q)
                S_IDLE:  if (launch)    state_q <= S_REQ;
                S_REQ:   if (req_ready) state_q <= S_WAIT;
                S_WAIT:  if (rsp_valid) state_q <= S_IDLE;
                default:                state_q <= S_IDLE;
            endcase
        end
    end

    // Capture the request fields once, at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_write <= 1'b0;
            req_addr  <= '0;
            req_fid   <= '0;
            req_wdata <= '0;
        end else if (launch && state_q == S_IDLE) begin
            req_write <= launch_write;
            req_addr  <= launch_addr;
            req_fid   <= launch_fid;
            req_wdata <= launch_wdata;
        end
    end

    assign req_valid = (state_q == S_REQ);
    assign busy      = (state_q != S_IDLE);
    assign rd_done   = (state_q == S_WAIT) && rsp_valid && !req_write;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_fid)
                                    && $stable(req_wdata) && $stable(req_write));

    // R8
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);

endmodule

// File: rtl/ircb_bridge.sv
// Module: host-facing indirect command bridge. It stages data, decodes the control word,
// applies the access-class rules and holds the data and status registers.
// Assumes the host bus width DW covers the 32-bit control word layout.
module ircb_bridge
    import ircb_pkg::*;
#(
    parameter int FID_W  = 16,
    parameter int ADDR_W = 12,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [FID_W-1:0]  req_fid,
    output logic [DW-1:0]     req_wdata,
    input  logic              rsp_valid,
    input  logic [2*DW-1:0]   rsp_data
);

    localparam int ADDR_LSB = FID_W;
    localparam int CMD_BIT  = DW - 1;

    logic [DW-1:0]     dlo_q, dhi_q;
    logic              err_q;
    logic              busy, rd_done;
    logic              ctrl_wr, stat_wr, dlo_wr;
    logic              cmd_write;
    logic [ADDR_W-1:0] win_addr;
    logic [FID_W-1:0]  win_fid;
    win_class_e        cls;
    logic              launch, zero_fill, err_set, err_clr;

    // Split the host write data into control fields.
    always_comb begin
        ctrl_wr   = host_we && (host_addr == OFF_CTRL);
        stat_wr   = host_we && (host_addr == OFF_STAT);
        dlo_wr    = host_we && (host_addr == OFF_DLO);
        cmd_write = host_wdata[CMD_BIT];
        win_addr  = host_wdata[ADDR_LSB +: ADDR_W];
        win_fid   = host_wdata[0 +: FID_W];
    end

    ircb_win_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (win_addr),
        .cls  (cls)
    );

    // Apply the access-class rules to a control write.
    always_comb begin
        launch    = ctrl_wr && !busy &&
                    ((cmd_write && cls == CLS_WO) || (!cmd_write && cls == CLS_RO));
        zero_fill = ctrl_wr && !busy && !cmd_write && (cls != CLS_RO);
        err_set   = ctrl_wr && (busy || (cmd_write && cls != CLS_WO) ||
                                (!cmd_write && cls == CLS_WO));
        err_clr   = stat_wr && host_wdata[STAT_ERR_BIT];
    end

    ircb_sequencer #(.FID_W(FID_W), .ADDR_W(ADDR_W), .DW(DW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .launch_write (cmd_write),
        .launch_addr  (win_addr),
        .launch_fid   (win_fid),
        .launch_wdata (dlo_q),
        .busy         (busy),
        .rd_done      (rd_done),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_fid      (req_fid),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid)
    );

    // Update the data registers. A response wins over a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlo_q <= '0;
            dhi_q <= '0;
        end else if (rd_done) begin
            dlo_q <= rsp_data[DW-1:0];
            dhi_q <= rsp_data[2*DW-1:DW];
        end else if (zero_fill) begin
            dlo_q <= '0;
            dhi_q <= '0;
        end else if (dlo_wr) begin
            dlo_q <= host_wdata;
        end
    end

    // Keep the sticky error flag. A set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (err_q && !err_clr) || err_set;
    end

    // Drive the host read mux.
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFF_DLO:  host_rdata = dlo_q;
            OFF_DHI:  host_rdata = dhi_q;
            OFF_STAT: begin
                host_rdata[STAT_BUSY_BIT] = busy;
                host_rdata[STAT_ERR_BIT]  = err_q;
            end
            default:  host_rdata = '0;
        endcase
    end

    // R2
    launch_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> req_valid && req_addr == $past(win_addr) && req_fid == $past(win_fid));

    // R6
    drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !busy && cmd_write && cls != CLS_WO |=> !req_valid && err_q);

    // R7
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !busy && !cmd_write && cls == CLS_WO |=> dlo_q == '0 && dhi_q == '0 && err_q);

    // R8
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && busy |=> err_q);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !err_clr |=> err_q);

    // R4
    rsp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> {dhi_q, dlo_q} == $past(rsp_data));

endmodule

// File: tb/tb_ircb_bridge.sv
// Bench: directed tests, one task per scenario, against a small target model.
module tb_ircb_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        req_valid, req_write;
    logic        req_ready = 1'b1;
    logic [11:0] req_addr;
    logic [15:0] req_fid;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic [63:0] rsp_data;

    int checks = 0;
    int errors = 0;

    // Target model state
    int          rsp_delay = 1;
    int          pend = 0;
    int          hs_cnt = 0;
    logic [63:0] tgt_rdata = '0;
    logic [11:0] cap_addr;
    logic [15:0] cap_fid;
    logic [31:0] cap_wdata;
    logic        cap_write;

    always #4 clk = ~clk;

    ircb_bridge dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_fid(req_fid), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data)
    );

    // Target: record handshakes and answer after rsp_delay cycles.
    always @(posedge clk) begin
        if (req_valid && req_ready) begin
            hs_cnt    <= hs_cnt + 1;
            cap_addr  <= req_addr;
            cap_fid   <= req_fid;
            cap_wdata <= req_wdata;
            cap_write <= req_write;
            pend      <= rsp_delay;
        end else if (pend > 0) begin
            pend <= pend - 1;
        end
    end
    assign rsp_valid = (pend == 1);
    assign rsp_data  = tgt_rdata;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [1:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    function automatic logic [31:0] ctrl(input logic wr, input logic [11:0] a, input logic [15:0] f);
        return {wr, 3'b000, a, f};
    endfunction

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 64; i++) begin
            hread(2'd3, s);
            if (!s[0]) return;
            @(negedge clk);
        end
        chk("R8 busy never released", 64'd1, 64'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        hread(2'd0, v); chk("R1 low data after reset", v, 0);
        hread(2'd1, v); chk("R1 high data after reset", v, 0);
        hread(2'd3, v); chk("R1 status after reset", v, 0);
        chk("R1 no request after reset", req_valid, 0);
    endtask

    task automatic t_write_wo();
        logic [31:0] v;
        int n0 = hs_cnt;
        hwrite(2'd0, 32'hA5A5_0F0F);
        hwrite(2'd2, ctrl(1'b1, 12'h405, 16'h1234) | 32'h7000_0000);
        hread(2'd3, v); chk("R8 busy after trigger", v[0], 1);
        wait_idle();
        chk("R3 one request", hs_cnt - n0, 1);
        chk("R3 address", cap_addr, 12'h405);
        chk("R3 fid", cap_fid, 16'h1234);
        chk("R3 write flag", cap_write, 1);
        chk("R3 data at trigger", cap_wdata, 32'hA5A5_0F0F);
        hread(2'd3, v); chk("R3 no error", v[1], 0);
        hwrite(2'd2, ctrl(1'b1, 12'h5A2, 16'h0001));
        wait_idle();
        chk("R3 attention clear accepted", hs_cnt - n0, 2);
    endtask

    task automatic t_read_ro(input logic [11:0] a, input logic [63:0] val);
        logic [31:0] v;
        int n0 = hs_cnt;
        tgt_rdata = val;
        hwrite(2'd2, ctrl(1'b0, a, 16'h00C3));
        wait_idle();
        chk("R4 one request", hs_cnt - n0, 1);
        chk("R4 read flag", cap_write, 0);
        chk("R4 address", cap_addr, a);
        hread(2'd0, v); chk("R4 low word", v, val[31:0]);
        hread(2'd1, v); chk("R4 high word", v, val[63:32]);
    endtask

    task automatic t_read_rsv();
        logic [31:0] v;
        int n0 = hs_cnt;
        hwrite(2'd2, ctrl(1'b0, 12'h100, 16'h0002));
        hread(2'd3, v); chk("R5 not busy", v[0], 0);
        chk("R5 no request", hs_cnt - n0, 0);
        hread(2'd0, v); chk("R5 low zero", v, 0);
        hread(2'd1, v); chk("R5 high zero", v, 0);
        hread(2'd3, v); chk("R5 no error", v[1], 0);
    endtask

    task automatic t_drop_write(input logic [11:0] a);
        logic [31:0] v;
        int n0 = hs_cnt;
        hwrite(2'd2, ctrl(1'b1, a, 16'h0003));
        repeat (3) @(negedge clk);
        chk("R6 no request", hs_cnt - n0, 0);
        hread(2'd3, v); chk("R6 error set", v[1], 1);
        repeat (2) @(negedge clk);
        hread(2'd3, v); chk("R9 error sticky", v[1], 1);
        hwrite(2'd3, 32'h0000_0001);
        hread(2'd3, v); chk("R9 bit0 write keeps error", v[1], 1);
        hwrite(2'd3, 32'h0000_0002);
        hread(2'd3, v); chk("R9 error cleared", v[1], 0);
    endtask

    task automatic t_read_wo();
        logic [31:0] v;
        int n0 = hs_cnt;
        hwrite(2'd2, ctrl(1'b0, 12'h5A1, 16'h0004));
        chk("R7 no request", hs_cnt - n0, 0);
        hread(2'd0, v); chk("R7 low zero", v, 0);
        hread(2'd1, v); chk("R7 high zero", v, 0);
        hread(2'd3, v); chk("R7 error set", v[1], 1);
        hwrite(2'd3, 32'h2);
    endtask

    task automatic t_hostmap();
        logic [31:0] v;
        hwrite(2'd0, 32'h1111_2222);
        hwrite(2'd1, 32'hDEAD_BEEF);
        hread(2'd1, v); chk("R2 high data write ignored", v, 32'h0);
        hread(2'd0, v); chk("R2 low data read back", v, 32'h1111_2222);
        hread(2'd2, v); chk("R2 control reads zero", v, 0);
    endtask

    task automatic t_stall();
        logic [31:0] v;
        int n0 = hs_cnt;
        req_ready = 1'b0;
        hwrite(2'd0, 32'h0BAD_F00D);
        hwrite(2'd2, ctrl(1'b1, 12'h500, 16'h00AA));
        hwrite(2'd0, 32'h7777_7777);
        repeat (3) @(negedge clk);
        chk("R10 valid held", req_valid, 1);
        chk("R10 address held", req_addr, 12'h500);
        chk("R10 data held", req_wdata, 32'h0BAD_F00D);
        hread(2'd3, v); chk("R8 busy while stalled", v[0], 1);
        req_ready = 1'b1;
        wait_idle();
        chk("R10 one request after stall", hs_cnt - n0, 1);
        chk("R3 data from trigger time", cap_wdata, 32'h0BAD_F00D);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        int n0;
        rsp_delay = 1;
        tgt_rdata = 64'hCAFE_0001_BEEF_0002;
        hwrite(2'd2, ctrl(1'b0, 12'h200, 16'h0010));
        hwrite(2'd0, 32'h5555_5555);
        wait_idle();
        hread(2'd0, v); chk("R11 response beats host write", v, 32'hBEEF_0002);
        hread(2'd1, v); chk("R11 high word", v, 32'hCAFE_0001);
        n0 = hs_cnt;
        tgt_rdata = 64'h0000_0009_0000_0008;
        hwrite(2'd2, ctrl(1'b0, 12'h5A3, 16'h0011));
        hwrite(2'd2, ctrl(1'b0, 12'h5A4, 16'h0012));
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R8 control on response edge ignored", hs_cnt - n0, 1);
        hread(2'd3, v); chk("R8 error on busy write", v[1], 1);
        hread(2'd0, v); chk("R8 first read kept", v, 32'h0000_0008);
        hwrite(2'd3, 32'h2);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_wo();
        t_read_ro(12'h200, 64'h0123_4567_89AB_CDEF);
        t_read_ro(12'h5A6, 64'hFEDC_BA98_7654_3210);
        t_read_rsv();
        t_drop_write(12'h488);
        t_drop_write(12'h5A3);
        t_read_wo();
        t_hostmap();
        t_stall();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule